// File: doc/BRIEF.md
# Nesting Priority Interrupt Dispatcher

This block turns request pulses from timer cells and software into handler dispatches for a processor. Each source keeps a pending bit. The pending bits act as the ready queue in hardware. Each source also has a programmable priority. Every cycle the block picks the highest-priority pending source and compares that priority with the running CPU priority. A dispatch is issued only when the pending priority is strictly higher.

On a dispatch, the running priority is pushed onto an internal LIFO and replaced by the source's priority. Handlers therefore nest strictly. A return pops the saved priority back.

A handler can lower the running priority after entry, from its trigger level to a lower execution level. Another source at the trigger level can then preempt it. This gives stack-based scheduling in which a later activation preempts an earlier one.

Top module: `nest_irq_dispatch`

## Requirements
- R1: A pulse on any of the `CELLS_PER_SRC` cell inputs routed to source s (bits `s*CELLS_PER_SRC` up to `s*CELLS_PER_SRC+CELLS_PER_SRC-1` of `cell_hit`), or on `sw_set[s]`, sets `pending[s]` at the next clock edge. Both paths have the same effect.
- R2: A write with `prio_we` stores `prio_val` as the priority of source `prio_sel`. The new value is used for arbitration from the following cycle. All priorities and the CPU priority reset to 0, so a source at priority 0 is never dispatched from reset.
- R3: A dispatch happens only when the best pending priority is strictly greater than `cpu_prio`. One cycle after the pending bit is visible, `dispatch` pulses for one cycle, `dispatch_idx` names the source, and `cpu_prio` takes that source's priority. `dispatch_idx` holds its value between dispatches.
- R4: Among pending sources that share the highest priority, the lowest index is dispatched.
- R5: A dispatch clears the chosen pending bit. If the same source is set in the same cycle, the bit stays set.
- R6: A dispatch pushes the previous `cpu_prio`. A `ret_req` pops the most recently saved value into `cpu_prio`, in LIFO order.
- R7: A `lower_we` write takes effect only when `lower_val` is strictly below `cpu_prio`. Otherwise it leaves `cpu_prio` unchanged.
- R8: After a handler lowers its priority, a pending source whose priority is above the new level preempts it, even when that source has the handler's original trigger priority.
- R9: When the stack already holds `STK_DEPTH` entries, a dispatch that would otherwise happen is withheld, the request stays pending, and `stack_err` is set. A `ret_req` with an empty stack leaves `cpu_prio` unchanged and sets `stack_err`. `stack_err` stays set until reset.
- R10: Per cycle, `ret_req` takes precedence over `lower_we`, and both take precedence over a dispatch. No dispatch is issued in a cycle with either request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_hit | input | N_SRC*CELLS_PER_SRC | Timer cell request pulses, grouped per source |
| sw_set | input | N_SRC | Software set-pending, one bit per source |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | IDX_W | Source whose priority is written |
| prio_val | input | PRIO_W | Priority value to write |
| lower_we | input | 1 | Request to lower the running priority |
| lower_val | input | PRIO_W | Requested lower running priority |
| ret_req | input | 1 | Handler return, pops saved priority |
| cpu_prio | output | PRIO_W | Current running priority |
| dispatch | output | 1 | One-cycle dispatch pulse |
| dispatch_idx | output | IDX_W | Index of the last dispatched source |
| pending | output | N_SRC | Pending bits (ready queue) |
| stack_err | output | 1 | Sticky nesting stack over/underflow flag |

## Verification
A set pulse shows on `pending` after one edge. The resulting dispatch, with its `cpu_prio` change and cleared pending bit, appears after a second edge. Priority, lower and return requests change `cpu_prio` and `stack_err` after one edge.

The bench drives each stimulus between edges and advances a requirement-level model by exactly one edge. It then compares all outputs shortly after that edge, so every result is checked in the cycle it is due. Directed sequences cover ties, same-cycle set and clear, lowering and preemption, and both stack limits. A seeded random phase follows.

// File: rtl/nid_pkg.sv
package nid_pkg;
   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_RET   = 2'd1,
      ACT_LOWER = 2'd2,
      ACT_DISP  = 2'd3
   } nid_act_e;
endpackage

// File: rtl/nid_pending.sv
module nid_pending #(
   parameter int N_SRC         = 8,
   parameter int CELLS_PER_SRC = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N_SRC*CELLS_PER_SRC-1:0] cell_hit,
   input  logic [N_SRC-1:0]               sw_set,
   input  logic [N_SRC-1:0]               clr_vec,
   output logic [N_SRC-1:0]               pend
);
   logic [N_SRC-1:0] set_vec;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      if (CELLS_PER_SRC == 1) begin : g_single
         assign set_vec[s] = cell_hit[s] | sw_set[s];
      end else begin : g_multi
         assign set_vec[s] = (|cell_hit[s*CELLS_PER_SRC +: CELLS_PER_SRC]) | sw_set[s];
      end

      // R5: a set request always wins over a same-cycle clear
      a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[s] |=> pend[s]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_vec) | set_vec;
   end

   // R1: a bit only rises when its source was requested
   a_r1_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[0]) |-> $past(set_vec[0]));
endmodule

// File: rtl/nid_arbiter.sv
module nid_arbiter #(
   parameter int N_SRC  = 8,
   parameter int PRIO_W = 8,
   localparam int IDX_W = $clog2(N_SRC)
) (
   input  logic [N_SRC-1:0]        pend,
   input  logic [N_SRC*PRIO_W-1:0] prio_flat,
   output logic                    found,
   output logic [IDX_W-1:0]        best_idx,
   output logic [PRIO_W-1:0]       best_prio
);
   always_comb begin
      found     = 1'b0;
      best_idx  = '0;
      best_prio = '0;
      for (int i = 0; i < N_SRC; i++) begin
         // strict compare keeps the lowest index on a tie (R4)
         if (pend[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) begin
            found     = 1'b1;
            best_idx  = IDX_W'(i);
            best_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/nid_prio_stack.sv
module nid_prio_stack #(
   parameter int DEPTH  = 4,
   parameter int PRIO_W = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] din,
   output logic [PRIO_W-1:0] top,
   output logic              full,
   output logic              empty
);
   logic [PRIO_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0]  cnt;

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);
   assign top   = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push && !full) begin
         mem[PTR_W'(cnt)] <= din;
         cnt              <= cnt + 1'b1;
      end else if (pop && !empty) begin
         cnt <= cnt - 1'b1;
      end
   end

   // R9: the caller never pushes a full stack nor pops an empty one
   a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
   // R6: occupancy stays within the configured depth
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/nest_irq_dispatch.sv
module nest_irq_dispatch
   import nid_pkg::*;
#(
   parameter int N_SRC         = 8,
   parameter int PRIO_W        = 8,
   parameter int STK_DEPTH     = 4,
   parameter int CELLS_PER_SRC = 4,
   localparam int IDX_W        = $clog2(N_SRC),
   localparam int CELL_W       = N_SRC * CELLS_PER_SRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CELL_W-1:0] cell_hit,
   input  logic [N_SRC-1:0]  sw_set,
   input  logic              prio_we,
   input  logic [IDX_W-1:0]  prio_sel,
   input  logic [PRIO_W-1:0] prio_val,
   input  logic              lower_we,
   input  logic [PRIO_W-1:0] lower_val,
   input  logic              ret_req,
   output logic [PRIO_W-1:0] cpu_prio,
   output logic              dispatch,
   output logic [IDX_W-1:0]  dispatch_idx,
   output logic [N_SRC-1:0]  pending,
   output logic              stack_err
);
   if (N_SRC < 2 || N_SRC > 256) begin : g_bad_nsrc
      $error("N_SRC must be in 2..256");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must be in 1..8 (at most 256 levels)");
   end
   if (STK_DEPTH < 2) begin : g_bad_depth
      $error("STK_DEPTH must be at least 2");
   end
   if (CELLS_PER_SRC < 1) begin : g_bad_cells
      $error("CELLS_PER_SRC must be at least 1");
   end

   logic [PRIO_W-1:0]       prio_q [N_SRC];
   logic [N_SRC*PRIO_W-1:0] prio_flat;
   logic [N_SRC-1:0]        clr_vec;
   logic                    found;
   logic [IDX_W-1:0]        best_idx;
   logic [PRIO_W-1:0]       best_prio;
   logic [PRIO_W-1:0]       stk_top;
   logic                    stk_full, stk_empty;
   logic                    want_disp, do_push, do_pop, ovf, unf;
   nid_act_e                act;

   for (genvar s = 0; s < N_SRC; s++) begin : g_prio
      assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
      assign clr_vec[s] = do_push && (best_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n)                                    prio_q[s] <= '0;
         else if (prio_we && prio_sel == IDX_W'(s))     prio_q[s] <= prio_val;
      end
   end

   nid_pending #(.N_SRC(N_SRC), .CELLS_PER_SRC(CELLS_PER_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .cell_hit(cell_hit), .sw_set(sw_set),
      .clr_vec(clr_vec), .pend(pending)
   );

   nid_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
      .pend(pending), .prio_flat(prio_flat), .found(found),
      .best_idx(best_idx), .best_prio(best_prio)
   );

   nid_prio_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .din(cpu_prio),
      .top(stk_top), .full(stk_full), .empty(stk_empty)
   );

   always_comb begin
      want_disp = found && (best_prio > cpu_prio);
      if (ret_req)        act = ACT_RET;
      else if (lower_we)  act = ACT_LOWER;
      else if (want_disp) act = ACT_DISP;
      else                act = ACT_IDLE;
      do_push = (act == ACT_DISP) && !stk_full;
      do_pop  = (act == ACT_RET) && !stk_empty;
      ovf     = (act == ACT_DISP) && stk_full;
      unf     = (act == ACT_RET) && stk_empty;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_prio     <= '0;
         dispatch     <= 1'b0;
         dispatch_idx <= '0;
         stack_err    <= 1'b0;
      end else begin
         dispatch <= do_push;
         if (ovf || unf) stack_err <= 1'b1;
         unique case (act)
            ACT_RET:   if (do_pop) cpu_prio <= stk_top;
            ACT_LOWER: if (lower_val < cpu_prio) cpu_prio <= lower_val;
            ACT_DISP:  if (do_push) begin
                          cpu_prio     <= best_prio;
                          dispatch_idx <= best_idx;
                       end
            default:   ;
         endcase
      end
   end

   // R3: a dispatch always raises the running priority
   a_r3_strict_raise: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch |-> cpu_prio > $past(cpu_prio));
   // R3: the chosen source was pending when picked
   a_r3_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
      do_push |-> pending[best_idx]);
   // R6: a return restores the saved priority
   a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req && !stk_empty) |=> cpu_prio == $past(stk_top));
   // R7: a lower request never raises the priority
   a_r7_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (lower_we && !ret_req) |=> cpu_prio <= $past(cpu_prio));
   // R10: no dispatch follows a cycle with return or lower
   a_r10_no_disp: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req || lower_we) |=> !dispatch);
   // R9: the error flag is sticky
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      stack_err |=> stack_err);
endmodule

// File: tb/nest_irq_dispatch_tb.sv
`timescale 1ns/100ps
module nest_irq_dispatch_tb;
   localparam int NS = 8;
   localparam int PW = 8;
   localparam int SD = 4;
   localparam int CP = 4;
   localparam int IW = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NS*CP-1:0] cell_hit = '0;
   logic [NS-1:0]  sw_set = '0;
   logic           prio_we = 1'b0;
   logic [IW-1:0]  prio_sel = '0;
   logic [PW-1:0]  prio_val = '0;
   logic           lower_we = 1'b0;
   logic [PW-1:0]  lower_val = '0;
   logic           ret_req = 1'b0;
   logic [PW-1:0]  cpu_prio;
   logic           dispatch;
   logic [IW-1:0]  dispatch_idx;
   logic [NS-1:0]  pending;
   logic           stack_err;

   always #2.5 clk = ~clk;

   nest_irq_dispatch #(.N_SRC(NS), .PRIO_W(PW), .STK_DEPTH(SD), .CELLS_PER_SRC(CP)) u_dut (
      .clk(clk), .rst_n(rst_n), .cell_hit(cell_hit), .sw_set(sw_set),
      .prio_we(prio_we), .prio_sel(prio_sel), .prio_val(prio_val),
      .lower_we(lower_we), .lower_val(lower_val), .ret_req(ret_req),
      .cpu_prio(cpu_prio), .dispatch(dispatch), .dispatch_idx(dispatch_idx),
      .pending(pending), .stack_err(stack_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // requirement-level model state
   bit [NS-1:0] m_pend = '0;
   int m_prio [NS];
   int m_cpu = 0;
   int m_stk [SD];
   int m_cnt = 0;
   bit m_err = 0;
   bit m_dv = 0;
   int m_di = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      chk(tag, "pending", int'(pending), int'(m_pend));
      chk(tag, "cpu_prio", int'(cpu_prio), m_cpu);
      chk(tag, "dispatch", int'(dispatch), int'(m_dv));
      chk(tag, "dispatch_idx", int'(dispatch_idx), m_di);
      chk(tag, "stack_err", int'(stack_err), int'(m_err));
   endtask

   // drive one cycle of stimulus, advance the model by one edge, compare after it
   task automatic step(input string tag, input logic [NS*CP-1:0] cells, input logic [NS-1:0] sw,
                       input bit pw, input int pidx, input int pval,
                       input bit lw, input int lval, input bit r);
      bit [NS-1:0] setv;
      bit [NS-1:0] clr;
      bit found;
      int bi;
      int bp;
      cell_hit = cells; sw_set = sw;
      prio_we = pw; prio_sel = IW'(pidx); prio_val = PW'(pval);
      lower_we = lw; lower_val = PW'(lval); ret_req = r;
      setv = sw;
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < CP; c++)
            if (cells[s*CP + c]) setv[s] = 1'b1;
      found = 0; bi = 0; bp = 0;
      for (int i = 0; i < NS; i++)
         if (m_pend[i] && (!found || m_prio[i] > bp)) begin
            found = 1; bi = i; bp = m_prio[i];
         end
      clr = '0;
      m_dv = 0;
      if (r) begin
         if (m_cnt == 0) m_err = 1;
         else begin m_cnt--; m_cpu = m_stk[m_cnt]; end
      end else if (lw) begin
         if (lval < m_cpu) m_cpu = lval;
      end else if (found && bp > m_cpu) begin
         if (m_cnt == SD) m_err = 1;
         else begin
            m_stk[m_cnt] = m_cpu; m_cnt++;
            m_cpu = bp; clr[bi] = 1'b1; m_dv = 1; m_di = bi;
         end
      end
      if (pw) m_prio[pidx] = pval;
      m_pend = (m_pend & ~clr) | setv;
      @(posedge clk);
      #1;
      compare_all(tag);
      @(negedge clk);
   endtask

   task automatic idle(input string tag, input int n);
      for (int k = 0; k < n; k++) step(tag, '0, '0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic setp(input string tag, input int idx, input int val);
      step(tag, '0, '0, 1, idx, val, 0, 0, 0);
   endtask

   task automatic swp(input string tag, input int idx);
      step(tag, '0, NS'(1) << idx, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic ret1(input string tag);
      step(tag, '0, '0, 0, 0, 0, 0, 0, 1);
   endtask

   task automatic apply_reset;
      rst_n = 1'b0;
      cell_hit = '0; sw_set = '0; prio_we = 0; lower_we = 0; ret_req = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_pend = '0; m_cpu = 0; m_cnt = 0; m_err = 0; m_dv = 0; m_di = 0;
      for (int i = 0; i < NS; i++) m_prio[i] = 0;
      for (int i = 0; i < SD; i++) m_stk[i] = 0;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      apply_reset();
      #1;
      compare_all("R2 reset state");
      @(negedge clk);

      // R2: priority 0 source never dispatches from reset
      swp("R2 prio zero held", 7);
      idle("R2 prio zero held", 3);

      setp("R2 prio write", 0, 5);
      setp("R2 prio write", 1, 5);
      setp("R2 prio write", 2, 9);
      setp("R2 prio write", 3, 9);
      setp("R2 prio write", 4, 3);
      setp("R2 prio write", 5, 5);
      setp("R2 prio write", 6, 200);

      // R1: one timer cell of source 4 sets its bit, then R3 dispatch
      step("R1 cell set", 32'(1) << (4*CP + 2), '0, 0, 0, 0, 0, 0, 0);
      idle("R3 dispatch s4", 2);

      // R4: tie at priority 5, lowest index wins
      step("R4 tie", '0, 8'b0000_0011, 0, 0, 0, 0, 0, 0);
      idle("R4 tie", 3);

      // R7: ignored lower (not below current), then accepted lower
      step("R7 ignored lower", '0, '0, 0, 0, 0, 1, 7, 0);
      step("R7 equal lower", '0, '0, 0, 0, 0, 1, 5, 0);
      step("R7 accepted lower", '0, '0, 0, 0, 0, 1, 4, 0);
      // R8: s1 at trigger priority 5 now preempts
      idle("R8 preempt after lower", 2);
      step("R8 lower again", '0, '0, 0, 0, 0, 1, 4, 0);
      swp("R8 later activation", 5);
      idle("R8 later activation", 2);

      // R9: stack is full (4 entries); s2 dispatch withheld
      swp("R9 overflow", 2);
      idle("R9 overflow", 2);

      // R6: unwind in LIFO order
      ret1("R6 pop");
      idle("R6 pop", 1);
      ret1("R6 pop");
      ret1("R6 pop");
      ret1("R6 pop");
      ret1("R6 pop");
      idle("R6 drain", 6);
      for (int k = 0; k < 6; k++) ret1("R9 underflow");

      // R5: set again in the cycle it is cleared
      apply_reset();
      setp("R5 setup", 3, 9);
      swp("R5 first set", 3);
      swp("R5 set during clear", 3);
      idle("R5 remains", 2);

      // R10: return and lower together, and lower blocks dispatch
      setp("R10 setup", 6, 200);
      swp("R10 setup", 6);
      step("R10 lower blocks disp", '0, '0, 0, 0, 0, 1, 1, 0);
      step("R10 ret beats lower", '0, '0, 0, 0, 0, 1, 0, 1);
      idle("R10 after", 3);
      ret1("R10 unwind");
      ret1("R10 unwind");

      // seeded random phase
      for (int k = 0; k < 3000; k++) begin
         logic [NS*CP-1:0] c;
         logic [NS-1:0] s;
         c = ($urandom_range(0, 7) == 0) ? (NS*CP)'($urandom) & (NS*CP)'($urandom) : '0;
         s = ($urandom_range(0, 3) == 0) ? NS'($urandom) & NS'($urandom) & NS'($urandom) : '0;
         step("R3 R4 R6 random", c, s,
              $urandom_range(0, 7) == 0, $urandom_range(0, NS-1), $urandom_range(0, 255),
              $urandom_range(0, 9) == 0, $urandom_range(0, 255),
              $urandom_range(0, 5) == 0);
         if (k % 1000 == 999) apply_reset();
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule